// File: doc/BRIEF.md
# Atomic Lock Window Unit

This unit sits next to the memory stage of two requesters, which may be two cores or two hardware threads of one core. It holds a small bank of lock words behind a reserved window at the very top of the address space. An ordinary load that lands in the window becomes an atomic read-and-set. The requester gets back the word's previous contents, and the word is left holding one. The load is held for exactly one extra cycle. A store into the window writes its data into the addressed word, so storing zero releases a lock. Any request outside the window is flagged as belonging to normal memory, and this unit does not handle it.

Each requester drives a valid/ready request channel. The requester raises valid with address, write flag and write data, and it must keep all of them unchanged until it sees ready high at a clock edge. That edge completes the transfer. For a read-and-set, ready first rises in the cycle after acceptance. In that response cycle the old value is presented, together with a busy flag that is high when the old value was nonzero. A multithreaded core can use that flag to switch threads. When both requesters contend in the same cycle, one is served and the other waits one more cycle. The winner alternates from one contention to the next. While one requester's read-and-set is waiting in its response cycle, any request from the other requester to the same word is held off.

Top module: `tas_lock_unit`

## Requirements
- R1: After reset every lock word is zero, so the first read-and-set of any word returns 0 with busy low, and with no request present ready and mem_pass are low.
- R2: A request whose address bits [AW-1:IDXW] are not all ones (for the defaults, any address below 0xFFFFFFF0) raises mem_pass while valid. It never gets ready from this unit and changes no lock word.
- R3: The word is selected by address bits [IDXW-1:0], one word per address (0xFFFFFFF0 is word 0, 0xFFFFFFF4 is word 4), and words do not affect one another.
- R4: A window load (we=0) returns the word's previous contents on rsp_data and leaves the word holding the value 1.
- R5: An uncontended window load has ready low in its first cycle and high in the next cycle, which is one stall cycle.
- R6: An uncontended window store (we=1) gets ready in the cycle it is presented and writes rq_wdata into the word. Writing zero releases the lock.
- R7: In the response cycle of a load, rsp_busy is high exactly when the returned old value is nonzero.
- R8: When both requesters present eligible window requests in the same cycle, exactly one is granted and the other waits one extra cycle. Port 0 wins the first contention after reset, and from then on the winner alternates between contentions.
- R9: While one port's read-and-set is in its response cycle, the other port's request to the same word is not granted. A request to a different word is granted.
- R10: A requester keeps valid and address stable from the first cycle of a window request until ready. Ready is the only back-pressure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rq_valid | input | NREQ | Request valid, one bit per requester |
| rq_we | input | NREQ | 1 = store, 0 = load (read-and-set) |
| rq_addr | input | NREQ x AW | Byte address per requester |
| rq_wdata | input | NREQ x DW | Store data per requester |
| rq_ready | output | NREQ | Transfer completes at an edge where valid and ready are both high |
| rsp_data | output | NREQ x DW | Previous word contents, valid while a load's ready is high |
| rsp_busy | output | NREQ | Old value was nonzero, valid in the load response cycle |
| mem_pass | output | NREQ | Request is outside the window and goes to normal memory |

## Verification
The assertions assume that requesters obey the hold rule. A window request keeps valid and address unchanged until ready, so the response cycle still points at the same word, and the hold-off comparison and the one-stall check depend on that. The assertions also assume that inputs are quiet during reset. The bench drives each request from a task that sets the port at a falling edge and holds it until it samples ready. It releases the port only after the completing edge. Requests that must collide are launched together, or one cycle apart, from parallel branches, so every contention and hold-off case arises only from legal traffic.

// File: rtl/tas_pkg.sv
package tas_pkg;
  localparam int NREQ = 2;

  typedef enum logic {
    OP_TAS   = 1'b0,
    OP_STORE = 1'b1
  } tas_op_e;
endpackage

// File: rtl/tas_window_decode.sv
module tas_window_decode #(
  parameter int AW   = 32,
  parameter int IDXW = 4
) (
  input  logic            valid,
  input  logic [AW-1:0]   addr,
  output logic            hit,
  output logic [IDXW-1:0] idx,
  output logic            pass
);
  localparam int TAGW = AW - IDXW;

  logic [TAGW-1:0] tag;

  always_comb begin
    tag  = addr[AW-1:IDXW];
    hit  = valid && (&tag);
    idx  = addr[IDXW-1:0];
    pass = valid && !(&tag);
  end
endmodule

// File: rtl/tas_pair_arbiter.sv
module tas_pair_arbiter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] req,
  output logic [1:0] gnt
);
  logic last_win;
  logic prio1;
  logic both;

  always_comb begin
    both   = req[0] && req[1];
    prio1  = !last_win;
    gnt[0] = req[0] && !(req[1] && prio1);
    gnt[1] = req[1] && !(req[0] && !prio1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_win <= 1'b1;
    end else if (both) begin
      last_win <= gnt[1];
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R8
  AST_GNT_ONLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == 2'b00); // R8
  AST_CONTEND_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    both |-> $countones(gnt) == 1); // R8
  AST_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && both && $past(both && gnt[0])) |-> gnt[1]); // R8
endmodule

// File: rtl/tas_lock_bank.sv
module tas_lock_bank #(
  parameter int NLOCK = 16,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(NLOCK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [IDXW-1:0] idx,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data
);
  logic [NLOCK-1:0][DW-1:0] words;

  always_comb rd_data = words[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NLOCK; i++) words[i] <= '0;
    end else if (wr_en) begin
      words[idx] <= wr_data;
    end
  end
endmodule

// File: rtl/tas_lock_unit.sv
module tas_lock_unit
  import tas_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int NLOCK = 16,
  localparam int IDXW = $clog2(NLOCK)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          rq_valid,
  input  logic [NREQ-1:0]          rq_we,
  input  logic [NREQ-1:0][AW-1:0]  rq_addr,
  input  logic [NREQ-1:0][DW-1:0]  rq_wdata,
  output logic [NREQ-1:0]          rq_ready,
  output logic [NREQ-1:0][DW-1:0]  rsp_data,
  output logic [NREQ-1:0]          rsp_busy,
  output logic [NREQ-1:0]          mem_pass
);
  logic [NREQ-1:0]            hit;
  logic [NREQ-1:0][IDXW-1:0]  idx;
  logic [NREQ-1:0]            pend;
  logic [NREQ-1:0]            blocked;
  logic [NREQ-1:0]            elig;
  logic [NREQ-1:0]            gnt;
  logic [NREQ-1:0][DW-1:0]    old_q;
  logic                       sel;
  logic                       any_gnt;
  logic [IDXW-1:0]            g_idx;
  logic [DW-1:0]              g_wdata;
  logic [DW-1:0]              bank_rd;
  tas_op_e                    g_op;

  for (genvar p = 0; p < NREQ; p++) begin : g_port
    localparam int Q = NREQ - 1 - p;

    tas_window_decode #(.AW(AW), .IDXW(IDXW)) u_dec (
      .valid (rq_valid[p]),
      .addr  (rq_addr[p]),
      .hit   (hit[p]),
      .idx   (idx[p]),
      .pass  (mem_pass[p])
    );

    always_comb begin
      blocked[p]  = pend[Q] && (idx[Q] == idx[p]);
      elig[p]     = hit[p] && !pend[p] && !blocked[p];
      rq_ready[p] = pend[p] || (gnt[p] && rq_we[p]);
      rsp_data[p] = old_q[p];
      rsp_busy[p] = pend[p] && (old_q[p] != '0);
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend[p]  <= 1'b0;
        old_q[p] <= '0;
      end else begin
        pend[p] <= gnt[p] && !rq_we[p];
        if (gnt[p] && !rq_we[p]) old_q[p] <= bank_rd;
      end
    end

    AST_TAS_ONE_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      (gnt[p] && !rq_we[p]) |=> rq_ready[p]); // R5
    AST_TAS_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (rq_ready[p] && !rq_we[p]) |-> ($past(rst_n) && $past(gnt[p]))); // R5
    AST_PASS_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
      mem_pass[p] |-> !rq_ready[p]); // R2
    AST_BUSY_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_busy[p] |-> (rq_ready[p] && !rq_we[p])); // R7
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[Q] && hit[p] && (idx[p] == idx[Q])) |-> !gnt[p]); // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[p] && !rq_ready[p]) |=> (rq_valid[p] && $stable(rq_addr[p]))); // R10
  end

  tas_pair_arbiter u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (elig),
    .gnt   (gnt)
  );

  always_comb begin
    sel     = gnt[1];
    any_gnt = |gnt;
    g_idx   = idx[sel];
    g_op    = rq_we[sel] ? OP_STORE : OP_TAS;
    g_wdata = (g_op == OP_STORE) ? rq_wdata[sel] : DW'(1);
  end

  tas_lock_bank #(.NLOCK(NLOCK), .DW(DW)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (any_gnt),
    .idx     (g_idx),
    .wr_data (g_wdata),
    .rd_data (bank_rd)
  );

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R8
endmodule

// File: tb/tas_lock_unit_tb_top.sv
module tas_lock_unit_tb_top;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        rq_valid = '0;
  logic [1:0]        rq_we = '0;
  logic [1:0][31:0]  rq_addr = '0;
  logic [1:0][31:0]  rq_wdata = '0;
  logic [1:0]        rq_ready;
  logic [1:0][31:0]  rsp_data;
  logic [1:0]        rsp_busy;
  logic [1:0]        mem_pass;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tas_lock_unit dut_i (
    .clk(clk), .rst_n(rst_n), .rq_valid(rq_valid), .rq_we(rq_we),
    .rq_addr(rq_addr), .rq_wdata(rq_wdata), .rq_ready(rq_ready),
    .rsp_data(rsp_data), .rsp_busy(rsp_busy), .mem_pass(mem_pass)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one window request on port p; returns stall cycles, data and busy
  task automatic req(input int p, input logic [31:0] a, input logic we, input logic [31:0] wd,
                     output int waits, output logic [31:0] d, output logic b);
    @(negedge clk);
    rq_valid[p] = 1'b1; rq_we[p] = we; rq_addr[p] = a; rq_wdata[p] = wd;
    waits = 0;
    forever begin
      #1;
      if (rq_ready[p]) break;
      @(negedge clk);
      waits++;
    end
    d = rsp_data[p];
    b = rsp_busy[p];
    @(posedge clk);
    #1 rq_valid[p] = 1'b0;
  endtask

  task automatic tas_chk(input int p, input int loc, input logic [31:0] exp,
                         input int exp_w, input string tag);
    int w; logic [31:0] d; logic b;
    req(p, 32'hFFFF_FFF0 | loc, 1'b0, '0, w, d, b);
    chk(d == exp, {tag, " old value"}, d, exp);
    chk(b == (exp != 0), {tag, " busy R7"}, b, exp != 0);
    chk(w == exp_w, {tag, " stall cycles"}, w, exp_w);
  endtask

  task automatic st_chk(input int p, input int loc, input logic [31:0] val, input string tag);
    int w; logic [31:0] d; logic b;
    req(p, 32'hFFFF_FFF0 | loc, 1'b1, val, w, d, b);
    chk(w == 0, {tag, " store stall"}, w, 0);
  endtask

  task automatic t_reset;
    @(negedge clk); #1;
    chk(rq_ready == 2'b00, "R1 ready idle", rq_ready, 0);
    chk(mem_pass == 2'b00, "R1 pass idle", mem_pass, 0);
    tas_chk(0, 3, 0, 1, "R1 R4 R5 first tas loc3");
  endtask

  task automatic t_setone;
    tas_chk(0, 3, 1, 1, "R4 second tas loc3");
    tas_chk(1, 4, 0, 1, "R3 loc4 untouched");
    tas_chk(1, 4, 1, 1, "R3 R4 loc4 now set");
  endtask

  task automatic t_store;
    st_chk(0, 3, 0, "R6 release loc3");
    tas_chk(0, 3, 0, 1, "R6 loc3 released");
    st_chk(1, 5, 32'hA5, "R6 store loc5");
    tas_chk(0, 5, 32'hA5, 1, "R6 R7 loc5 data");
    tas_chk(0, 5, 1, 1, "R4 loc5 set to one");
  endtask

  task automatic t_outside;
    @(negedge clk);
    rq_valid[1] = 1'b1; rq_we[1] = 1'b1; rq_addr[1] = 32'h1000_0000; rq_wdata[1] = 32'h77;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(mem_pass[1] == 1'b1, "R2 pass raised", mem_pass[1], 1);
      chk(rq_ready[1] == 1'b0, "R2 no ready", rq_ready[1], 0);
      @(negedge clk);
    end
    rq_addr[1] = 32'hFFFF_FFEF; rq_we[1] = 1'b0;
    #1;
    chk(mem_pass[1] == 1'b1, "R2 edge below window", mem_pass[1], 1);
    @(negedge clk);
    rq_valid[1] = 1'b0;
    tas_chk(0, 0, 0, 1, "R2 loc0 unchanged");
  endtask

  task automatic t_contend;
    int w0, w1; logic [31:0] d0, d1; logic b0, b1;
    fork
      req(0, 32'hFFFF_FFF6, 1'b0, '0, w0, d0, b0);
      req(1, 32'hFFFF_FFF7, 1'b0, '0, w1, d1, b1);
    join
    chk(w0 == 1, "R8 first contention p0 wins", w0, 1);
    chk(w1 == 2, "R8 first contention p1 waits", w1, 2);
    chk(d0 == 0 && d1 == 0, "R8 contention data", {d0, d1}, 0);
    fork
      req(0, 32'hFFFF_FFF6, 1'b1, 32'h11, w0, d0, b0);
      req(1, 32'hFFFF_FFF7, 1'b1, 32'h22, w1, d1, b1);
    join
    chk(w1 == 0, "R8 second contention p1 wins", w1, 0);
    chk(w0 == 1, "R8 second contention p0 waits", w0, 1);
    tas_chk(0, 6, 32'h11, 1, "R8 loc6 data");
    tas_chk(1, 7, 32'h22, 1, "R8 loc7 data");
  endtask

  task automatic t_holdoff;
    int w0, w1; logic [31:0] d0, d1; logic b0, b1;
    fork
      req(0, 32'hFFFF_FFFA, 1'b0, '0, w0, d0, b0);
      begin @(negedge clk); req(1, 32'hFFFF_FFFA, 1'b1, 32'h3C, w1, d1, b1); end
    join
    chk(w0 == 1 && d0 == 0, "R9 tas loc10", w0, 1);
    chk(w1 == 1, "R9 same-word store held off", w1, 1);
    tas_chk(0, 10, 32'h3C, 1, "R9 store after tas");
    fork
      req(0, 32'hFFFF_FFFB, 1'b0, '0, w0, d0, b0);
      begin @(negedge clk); req(1, 32'hFFFF_FFFC, 1'b1, 32'h44, w1, d1, b1); end
    join
    chk(w1 == 0, "R9 other-word store not held", w1, 0);
    tas_chk(1, 12, 32'h44, 1, "R9 loc12 data");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_setone();
    t_store();
    t_outside();
    t_contend();
    t_holdoff();
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x1 expected=0x0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule